// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns transfer requests from the processor side into complete bus cycles on a 20-bit multiplexed bus. The low 16 lines carry the address first and then the data. The upper 4 lines carry the high address bits first and then cycle status. Each cycle runs through the T-states T1, T2, T3, optional wait states Tw, and T4. Each T-state is one clock period. The block drives the address strobe, the read and write strobes, memory/IO select, transceiver direction and transceiver enable. It also drives a shared byte-high-enable/status line. Every output group has its own output enable so the pads can be floated.

Requests enter on a valid/ready handshake. `req_ready` is high only when the sequencer is idle or in T4 and `hold` is low. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and all of its fields are latched at that edge. Back-pressure is therefore the length of the bus cycle, plus any wait states, plus any hold period. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse in T4, and the consumer must take `rsp_rdata` in that cycle.

An external master can take the bus with `hold`. The current cycle always completes first. The block then floats every output group and raises `hlda` until `hold` drops.

Top module: `mux_bus_seq`

## Requirements
- R1: A cycle with `ready` high at the end of T3 lasts exactly four clocks (T1, T2, T3, T4). T1 begins on the clock after the accepting edge. `req_ready` is high only in idle or T4 with `hold` low.
- R2: `ale` is high only in T1. In T1, `ad_out` equals address bits 15..0 with `ad_oe`=1, `ahs_out` equals address bits 19..16, and `bhe_s7_n` equals the requested byte-high-enable (active low).
- R3: From T2 through T4, `ahs_out` carries status: bit 3 = 0, bit 2 = the request's interrupt flag, and bits 1..0 = the segment code (00 extra, 01 stack, 10 code, 11 data). `bhe_s7_n` is 1 over the same span.
- R4: From T1 through T4, `m_io` is 1 for a memory cycle and 0 for an I/O cycle, and `dt_r` is 1 for a write and 0 for a read.
- R5: `rd_n` (reads) or `wr_n` (writes) is low in T2, T3 and every Tw, and `den_n` is low in the same cycles. All three are high in T1, T4 and idle. `rd_n` and `wr_n` are never low together.
- R6: `ready` is sampled on the clock edge that ends T3 and on the edge that ends each Tw. Each low sample adds one Tw of one clock.
- R7: During a write, `ad_out` carries the write data with `ad_oe`=1 from T2 through T4. During a read, `ad_oe` is 0 from T2 through T4.
- R8: `ad_in` is captured on the edge that leaves the last T3 or Tw. `rsp_valid` is high for exactly the one T4 clock, with the captured value on `rsp_rdata`.
- R9: When `hold` is high, the running cycle completes. From the clock after T4 (or after idle), `hlda` is 1 and `ad_oe`, `ahs_oe` and `ctrl_oe` are 0. No request is accepted during hold. One clock after `hold` falls, the block is idle again.
- R10: A request that is valid during T4 starts its T1 on the very next clock, with no idle clock between the two cycles.
- R11: After reset the block is idle: `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `ad_oe`=0, `hlda`=0, `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period per T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bhe_n | input | 1 | Byte-high enable, active low |
| req_seg | input | 2 | Segment code reported as status |
| req_iflag | input | 1 | Interrupt-enable flag reported as status |
| rsp_valid | output | 1 | One-clock completion pulse in T4 |
| rsp_rdata | output | 16 | Captured read data |
| ad_in | input | 16 | Multiplexed lines, inbound value |
| ad_out | output | 16 | Multiplexed lines, outbound value |
| ad_oe | output | 1 | Output enable for ad_out |
| ahs_out | output | 4 | Upper address / status lines |
| ahs_oe | output | 1 | Output enable for ahs_out and bhe_s7_n |
| bhe_s7_n | output | 1 | Byte-high enable, then status bit 7 |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | Memory (1) or I/O (0) |
| dt_r | output | 1 | Transceiver direction: transmit (1) / receive (0) |
| den_n | output | 1 | Transceiver enable, active low |
| ctrl_oe | output | 1 | Output enable for the control strobes |
| ready | input | 1 | Wait-state request, low inserts Tw |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Hold acknowledge |

## Verification
The embedded assertions check every clock for the rules that follow from one step of the state sequence. T1 always leads to T2 and T2 to T3. A low `ready` at the end of T3 always yields a Tw. `ale` never lasts two clocks. The two strobes are never low together. The completion pulse is a single clock. Every output group is floated while `hlda` is high. The address and status contents of the shared lines, the exact clock in which read data is captured, the cycle count under varied wait lengths, back-to-back starts and the hold hand-over need whole-transfer scenarios. The bench runs these with randomized addresses, data, segment codes and wait counts, and checks them against values it derives itself.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } tstate_e;

  localparam int unsigned STAT_BITS = 4;

  function automatic logic in_cycle(input tstate_e s);
    return (s == ST_T1) || (s == ST_T2) || (s == ST_T3) ||
           (s == ST_TW) || (s == ST_T4);
  endfunction

  function automatic logic after_t1(input tstate_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW) || (s == ST_T4);
  endfunction

  function automatic logic strobe_phase(input tstate_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_mem,
  input  logic              req_write,
  input  logic              req_bhe_n,
  input  logic [1:0]        req_seg,
  input  logic              req_iflag,
  input  logic              ready,
  input  logic              hold,
  input  logic [DATA_W-1:0] ad_in,
  output tstate_e           state,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              cur_mem,
  output logic              cur_write,
  output logic              cur_bhe_n,
  output logic [1:0]        cur_seg,
  output logic              cur_iflag,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              hlda
);
  tstate_e state_q, state_d;
  logic    accept;
  logic    boundary;

  assign boundary  = (state_q == ST_IDLE) || (state_q == ST_T4);
  assign req_ready = boundary && !hold;
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_T4: begin
        if (hold)           state_d = ST_HOLD;
        else if (req_valid) state_d = ST_T1;
        else                state_d = ST_IDLE;
      end
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = ready ? ST_T4 : ST_TW;
      ST_HOLD: state_d = hold ? ST_HOLD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_mem   <= 1'b0;
      cur_write <= 1'b0;
      cur_bhe_n <= 1'b1;
      cur_seg   <= 2'b00;
      cur_iflag <= 1'b0;
    end else if (accept) begin
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
      cur_mem   <= req_mem;
      cur_write <= req_write;
      cur_bhe_n <= req_bhe_n;
      cur_seg   <= req_seg;
      cur_iflag <= req_iflag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (((state_q == ST_T3) || (state_q == ST_TW)) && ready) begin
      rsp_rdata <= ad_in;
    end
  end

  assign state     = state_q;
  assign rsp_valid = (state_q == ST_T4);
  assign hlda      = (state_q == ST_HOLD);

  assert_accept_t1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q == ST_T1));
  assert_t1_t2_t3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_T1) |=> (state_q == ST_T2));
  assert_t2_t3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_T2) |=> (state_q == ST_T3));
  assert_wait_insert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (((state_q == ST_T3) || (state_q == ST_TW)) && !ready) |=> (state_q == ST_TW));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_no_accept_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !req_ready);
endmodule

// File: rtl/bus_seq_admux.sv
module bus_seq_admux
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  tstate_e           state,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic              cur_write,
  input  logic              cur_bhe_n,
  input  logic [1:0]        cur_seg,
  input  logic              cur_iflag,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] ahs_out,
  output logic              ahs_oe,
  output logic              bhe_s7_n
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [HI_W-1:0] status_word;

  always_comb begin
    status_word = '0;
    status_word[STAT_BITS-1:0] = {1'b0, cur_iflag, cur_seg};
  end

  always_comb begin
    ad_out   = '0;
    ad_oe    = 1'b0;
    ahs_out  = '0;
    ahs_oe   = in_cycle(state);
    bhe_s7_n = 1'b1;
    if (state == ST_T1) begin
      ad_out   = cur_addr[DATA_W-1:0];
      ad_oe    = 1'b1;
      ahs_out  = cur_addr[ADDR_W-1:DATA_W];
      bhe_s7_n = cur_bhe_n;
    end else if (after_t1(state)) begin
      ad_out   = cur_wdata;
      ad_oe    = cur_write;
      ahs_out  = status_word;
      bhe_s7_n = 1'b1;
    end
  end
endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  tstate_e state,
  input  logic    cur_mem,
  input  logic    cur_write,
  output logic    ale,
  output logic    rd_n,
  output logic    wr_n,
  output logic    m_io,
  output logic    dt_r,
  output logic    den_n,
  output logic    ctrl_oe
);
  logic strobe_on;
  logic active;

  assign strobe_on = strobe_phase(state);
  assign active    = in_cycle(state);

  assign ale     = (state == ST_T1);
  assign rd_n    = !(strobe_on && !cur_write);
  assign wr_n    = !(strobe_on && cur_write);
  assign den_n   = !strobe_on;
  assign m_io    = active ? cur_mem : 1'b0;
  assign dt_r    = active ? cur_write : 1'b0;
  assign ctrl_oe = (state != ST_HOLD);

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_mem,
  input  logic                     req_write,
  input  logic                     req_bhe_n,
  input  logic [1:0]               req_seg,
  input  logic                     req_iflag,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] ahs_out,
  output logic                     ahs_oe,
  output logic                     bhe_s7_n,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     m_io,
  output logic                     dt_r,
  output logic                     den_n,
  output logic                     ctrl_oe,
  input  logic                     ready,
  input  logic                     hold,
  output logic                     hlda
);
  tstate_e           state;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_mem, cur_write, cur_bhe_n, cur_iflag;
  logic [1:0]        cur_seg;

  bus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mem(req_mem),
    .req_write(req_write), .req_bhe_n(req_bhe_n), .req_seg(req_seg),
    .req_iflag(req_iflag), .ready(ready), .hold(hold), .ad_in(ad_in),
    .state(state), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .cur_mem(cur_mem), .cur_write(cur_write), .cur_bhe_n(cur_bhe_n),
    .cur_seg(cur_seg), .cur_iflag(cur_iflag),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .hlda(hlda)
  );

  bus_seq_admux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_admux (
    .state(state), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .cur_write(cur_write), .cur_bhe_n(cur_bhe_n), .cur_seg(cur_seg),
    .cur_iflag(cur_iflag), .ad_out(ad_out), .ad_oe(ad_oe),
    .ahs_out(ahs_out), .ahs_oe(ahs_oe), .bhe_s7_n(bhe_s7_n)
  );

  bus_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .state(state),
    .cur_mem(cur_mem), .cur_write(cur_write),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r),
    .den_n(den_n), .ctrl_oe(ctrl_oe)
  );

  assert_float_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe && !ahs_oe && !ctrl_oe));
  assert_ale_drives_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && ahs_oe && rd_n && wr_n));
endmodule

// File: tb/mux_bus_seq_tb_top.sv
module mux_bus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_mem = 1'b0, req_write = 1'b0, req_bhe_n = 1'b1, req_iflag = 1'b0;
  logic [1:0]  req_seg = 2'b00;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  ahs_out;
  logic        ahs_oe, bhe_s7_n, ale, rd_n, wr_n, m_io, dt_r, den_n, ctrl_oe;
  logic        ready = 1'b1, hold = 1'b0;
  logic        hlda;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  mux_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mem(req_mem),
    .req_write(req_write), .req_bhe_n(req_bhe_n), .req_seg(req_seg),
    .req_iflag(req_iflag), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ahs_out(ahs_out),
    .ahs_oe(ahs_oe), .bhe_s7_n(bhe_s7_n), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r), .den_n(den_n),
    .ctrl_oe(ctrl_oe), .ready(ready), .hold(hold), .hlda(hlda)
  );

  function automatic logic [3:0] exp_status(input logic ifl, input logic [1:0] seg);
    return {1'b0, ifl, seg};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R11 ale"}, ale, 1'b0);
    chk({tag, " R5 strobes"}, {rd_n, wr_n, den_n}, 3'b111);
    chk({tag, " R11 ad_oe"}, ad_oe, 1'b0);
    chk({tag, " R11 hlda"}, hlda, 1'b0);
    chk({tag, " R11 rsp_valid"}, rsp_valid, 1'b0);
    chk({tag, " R11 req_ready"}, req_ready, 1'b1);
  endtask

  task automatic idle_gap(input int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_idle("gap");
    end
  endtask

  // Called at a negedge where the sequencer sits in idle or T4.
  task automatic run_cycle(input logic [19:0] a, input logic [15:0] d,
                           input logic mem, input logic wr, input logic bhe,
                           input logic [1:0] seg, input logic ifl,
                           input int nw, input logic hold_mid);
    logic [3:0] st;
    st = exp_status(ifl, seg);
    req_addr = a; req_wdata = d; req_mem = mem; req_write = wr;
    req_bhe_n = bhe; req_seg = seg; req_iflag = ifl; req_valid = 1'b1;
    chk("R1 req_ready at boundary", req_ready, 1'b1);
    @(negedge clk); // T1
    req_valid = 1'b0;
    req_wdata = ~d;
    chk("R2 ale in T1", ale, 1'b1);
    chk("R2 address low", ad_out, a[15:0]);
    chk("R2 ad_oe in T1", ad_oe, 1'b1);
    chk("R2 address high", ahs_out, a[19:16]);
    chk("R2 bhe in T1", bhe_s7_n, bhe);
    chk("R4 m_io", m_io, mem);
    chk("R4 dt_r", dt_r, wr);
    chk("R5 strobes high in T1", {rd_n, wr_n, den_n}, 3'b111);
    chk("R1 busy in T1", req_ready, 1'b0);
    if (hold_mid) hold = 1'b1;
    @(negedge clk); // T2
    chk("R2 ale low in T2", ale, 1'b0);
    chk("R3 status", ahs_out, st);
    chk("R3 S7", bhe_s7_n, 1'b1);
    chk("R5 rd_n T2", rd_n, wr);
    chk("R5 wr_n T2", wr_n, !wr);
    chk("R5 den_n T2", den_n, 1'b0);
    chk("R7 ad_oe T2", ad_oe, wr);
    if (wr) chk("R7 write data T2", ad_out, d);
    chk("R4 m_io T2", m_io, mem);
    @(negedge clk); // T3
    ready = (nw == 0);
    ad_in = d;
    chk("R5 strobe T3", {rd_n, wr_n}, {wr, !wr});
    chk("R3 status T3", ahs_out, st);
    chk("R8 no done T3", rsp_valid, 1'b0);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk); // Tw
      chk("R6 wait state held", rsp_valid, 1'b0);
      chk("R5 strobe Tw", {rd_n, wr_n, den_n}, {wr, !wr, 1'b0});
      chk("R4 dt_r Tw", dt_r, wr);
      ready = (i == nw - 1);
    end
    @(negedge clk); // T4
    ready = 1'b1;
    ad_in = ~d;
    chk("R8 done in T4", rsp_valid, 1'b1);
    if (!wr) chk("R8 read data", rsp_rdata, d);
    chk("R5 strobes released T4", {rd_n, wr_n, den_n}, 3'b111);
    chk("R3 status T4", ahs_out, st);
    chk("R7 ad_oe T4", ad_oe, wr);
    if (wr) chk("R7 write data T4", ad_out, d);
    chk("R9 ready gated by hold", req_ready, !hold_mid);
  endtask

  task automatic hold_phase(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk("R9 hlda", hlda, 1'b1);
      chk("R9 float", {ad_oe, ahs_oe, ctrl_oe}, 3'b000);
      chk("R9 no accept", req_ready, 1'b0);
      req_valid = 1'b1;
      req_addr = 20'hABCDE;
    end
    hold = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 back to idle", hlda, 1'b0);
    chk_idle("post-hold");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("reset R11");

    // Directed corner cases
    run_cycle(20'h12345, 16'hBEEF, 1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 0, 1'b0);
    idle_gap(1);
    run_cycle(20'hF00AA, 16'h5A5A, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 2, 1'b0);
    idle_gap(2);
    run_cycle(20'h0FFFF, 16'hC3C3, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 3, 1'b0);
    // R10 back-to-back: next request issued during T4
    run_cycle(20'h8ACE1, 16'h1357, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 0, 1'b0);
    run_cycle(20'h2468A, 16'h9BDF, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 1, 1'b0);
    // R9 hold raised mid-cycle
    run_cycle(20'h55555, 16'hAAAA, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1, 1, 1'b1);
    hold_phase(3);
    // R9 hold raised while idle, with a pending request
    hold = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    chk("R9 hlda from idle", hlda, 1'b1);
    chk("R9 no cycle started", ale, 1'b0);
    hold_phase(2);

    // Constrained random traffic
    for (int k = 0; k < 300; k++) begin
      logic [19:0] a;
      logic [15:0] d;
      logic [3:0]  r;
      int          nw;
      int          gap;
      a   = 20'($urandom);
      d   = 16'($urandom);
      r   = 4'($urandom);
      nw  = int'($urandom_range(0, 4));
      gap = int'($urandom_range(0, 2));
      run_cycle(a, d, r[0], r[1], r[2], 2'($urandom), r[3], nw, 1'b0);
      if (gap != 0) idle_gap(gap);
    end
    idle_gap(1);

    done_flag = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule